// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between the asynchronous control pins at a processor's boundary and the core's exception logic. It brings every pin into the core clock domain, remembers the last level it acted on for each pin, and does something only when a pin settles at a new level. What it does depends on the pin. Some pins are mirrored into pending-interrupt bits. One pin is a latched, active-low machine-check event. One pin halts the core. One pin produces a single-cycle core reset pulse. One pin gates the time base.

The pin vector uses a fixed bit assignment:

| Bit | Pin |
|-----|-----|
| 0 | external interrupt |
| 1 | system-management interrupt |
| 2 | machine check, active low |
| 3 | checkstop |
| 4 | hard reset |
| 5 | soft reset |
| 6 | time-base enable |
| 7 and up | spare |

The pending vector uses its own bit assignment:

| Bit | Source |
|-----|--------|
| 0 | external |
| 1 | system-management |
| 2 | machine check |
| 3 | soft reset |

The core acknowledges latched pending bits through a per-bit acknowledge input. A build parameter decides whether a checkstop halt can be lifted by releasing the pin.

Top module: `irq_pin_cond`

## Requirements
- R1: A pin change made before rising edge k appears on the outputs after rising edge k+2. Before that edge the outputs do not show it.
- R2: Pin bits 0, 1 and 5 are mirrored into pending bits 0, 1 and 3. A high level sets the bit and a low level clears it.
- R3: Pending bit 2 is set only when pin bit 2 falls from high to low. A rise of that pin leaves the bit unchanged. Holding the pin low after an acknowledge does not set the bit again.
- R4: Acknowledge bit 2 clears pending bit 2 at the next edge. Acknowledge bits 0, 1 and 3 have no effect on the mirrored bits.
- R5: A rise of pin bit 4 produces a core reset pulse that is high for exactly one cycle. A fall of that pin produces no pulse.
- R6: A rise of pin bit 3 sets the halt output. When RESTART_CKSTOP is 1, a fall of that pin clears halt. When it is 0, halt stays set until reset.
- R7: The hard-interrupt output is high in exactly the cycles in which at least one pending bit is set.
- R8: The time-base run output follows the settled level of pin bit 6.
- R9: Changes on spare pin bits (bit 7 and above) have no effect on any output.
- R10: After reset, all outputs are low. The stored level of the machine-check pin starts high and all other stored levels start low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pin_i | input | PIN_W | asynchronous control pins |
| ack_i | input | 4 | per-bit pending acknowledge from the core |
| pending_o | output | 4 | pending-interrupt vector |
| hard_irq_o | output | 1 | combined interrupt request |
| halt_o | output | 1 | halt flag |
| core_rst_o | output | 1 | one-cycle core reset pulse |
| tb_run_o | output | 1 | time-base enable |

## Verification
Every pin-driven result is due at the third rising edge after the pin changes: two synchroniser flops plus the output register. Acknowledge bypasses the synchroniser, so it takes effect at the very next edge. The bench's reference model delays its pin samples by two edges in a queue and then applies the rules at the third edge. It compares against the design at each falling edge. Directed checks wait exactly three falling edges after a pin change, and they also probe one edge early to confirm that nothing has moved yet. Pulse width is measured by counting high samples over a window.

// File: rtl/irq_pin_cond_pkg.sv
package irq_pin_cond_pkg;

    // Pin positions in the input vector.
    localparam int PIN_EXT    = 0;
    localparam int PIN_SMI    = 1;
    localparam int PIN_MCK_N  = 2;
    localparam int PIN_CKSTOP = 3;
    localparam int PIN_HRST   = 4;
    localparam int PIN_SRST   = 5;
    localparam int PIN_TBEN   = 6;
    localparam int NUM_DEF    = 7;

    // Pending vector positions.
    localparam int PND_EXT  = 0;
    localparam int PND_SMI  = 1;
    localparam int PND_MCK  = 2;
    localparam int PND_SRST = 3;
    localparam int PEND_W   = 4;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              hirq;
        logic              halt;
        logic              crst;
        logic              tbrun;
    } cond_state_t;

    // Idle pin level: only the active-low machine check rests high.
    function automatic logic [NUM_DEF-1:0] def_idle();
        logic [NUM_DEF-1:0] v;
        v = '0;
        v[PIN_MCK_N] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int                 W      = 8,
    parameter int                 STAGES = 2,
    parameter logic [W-1:0]       IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= IDLE;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
    import irq_pin_cond_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_W-1:0]   sync_i,
    output logic [NUM_DEF-1:0] rise_o,
    output logic [NUM_DEF-1:0] fall_o
);

    localparam logic [NUM_DEF-1:0] IDLE = def_idle();

    logic [NUM_DEF-1:0] last_d, last_q;

    // Only the defined pins have a stored level; a change updates it.
    always_comb begin
        last_d = last_q;
        rise_o = '0;
        fall_o = '0;
        for (int i = 0; i < NUM_DEF; i++) begin
            if (sync_i[i] != last_q[i]) begin
                last_d[i] = sync_i[i];
                rise_o[i] = sync_i[i];
                fall_o[i] = !sync_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IDLE;
        else        last_q <= last_d;
    end

    generate
        if (PIN_W > NUM_DEF) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^sync_i[PIN_W-1:NUM_DEF];
        end
    endgenerate

endmodule

// File: rtl/irq_pin_core.sv
module irq_pin_core
    import irq_pin_cond_pkg::*;
#(
    parameter bit RESTART_CKSTOP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEF-1:0] rise_i,
    input  logic [NUM_DEF-1:0] fall_i,
    input  logic [PEND_W-1:0]  ack_i,
    output cond_state_t        st_o
);

    cond_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.crst = 1'b0;

        // Level-mirrored sources; acknowledge does not touch these.
        if (rise_i[PIN_EXT])  st_d.pend[PND_EXT]  = 1'b1;
        if (fall_i[PIN_EXT])  st_d.pend[PND_EXT]  = 1'b0;
        if (rise_i[PIN_SMI])  st_d.pend[PND_SMI]  = 1'b1;
        if (fall_i[PIN_SMI])  st_d.pend[PND_SMI]  = 1'b0;
        if (rise_i[PIN_SRST]) st_d.pend[PND_SRST] = 1'b1;
        if (fall_i[PIN_SRST]) st_d.pend[PND_SRST] = 1'b0;

        // Latched machine check: cleared by the core, set by a falling pin.
        if (ack_i[PND_MCK])     st_d.pend[PND_MCK] = 1'b0;
        if (fall_i[PIN_MCK_N])  st_d.pend[PND_MCK] = 1'b1;

        // Checkstop halt.
        if (rise_i[PIN_CKSTOP])
            st_d.halt = 1'b1;
        else if (fall_i[PIN_CKSTOP] && RESTART_CKSTOP)
            st_d.halt = 1'b0;

        // Hard reset: one pulse on assertion only.
        if (rise_i[PIN_HRST]) st_d.crst = 1'b1;

        // Time-base gate.
        if (rise_i[PIN_TBEN]) st_d.tbrun = 1'b1;
        if (fall_i[PIN_TBEN]) st_d.tbrun = 1'b0;

        st_d.hirq = |st_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
    import irq_pin_cond_pkg::*;
#(
    parameter int PIN_W          = 8,
    parameter int SYNC_STAGES    = 2,
    parameter bit RESTART_CKSTOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic [PEND_W-1:0] ack_i,
    output logic [PEND_W-1:0] pending_o,
    output logic              hard_irq_o,
    output logic              halt_o,
    output logic              core_rst_o,
    output logic              tb_run_o
);

    localparam logic [PIN_W-1:0] SYNC_IDLE = PIN_W'(def_idle());

    logic [PIN_W-1:0]   pin_sync;
    logic [NUM_DEF-1:0] rise, fall;
    cond_state_t        st;

    irq_pin_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .IDLE   (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    irq_pin_edge #(
        .PIN_W (PIN_W)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync),
        .rise_o (rise),
        .fall_o (fall)
    );

    irq_pin_core #(
        .RESTART_CKSTOP (RESTART_CKSTOP)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .fall_i (fall),
        .ack_i  (ack_i),
        .st_o   (st)
    );

    assign pending_o  = st.pend;
    assign hard_irq_o = st.hirq;
    assign halt_o     = st.halt;
    assign core_rst_o = st.crst;
    assign tb_run_o   = st.tbrun;

endmodule

// File: rtl/irq_pin_cond_chk.sv
module irq_pin_cond_chk
    import irq_pin_cond_pkg::*;
#(
    parameter bit RESTART_CKSTOP = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PEND_W-1:0] ack_i,
    input logic [PEND_W-1:0] pending_o,
    input logic              hard_irq_o,
    input logic              halt_o,
    input logic              core_rst_o
);

    AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o); // R5

    AST_MCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o[PND_MCK] && !ack_i[PND_MCK]) |=> pending_o[PND_MCK]); // R3

    AST_MCK_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending_o[PND_MCK]) |-> $past(ack_i[PND_MCK])); // R4

    AST_IRQ_DROP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_irq_o) |-> (pending_o == '0)); // R7

    AST_IRQ_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o != '0) |-> hard_irq_o); // R7

    AST_HALT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!RESTART_CKSTOP && halt_o) |=> halt_o); // R6

endmodule

bind irq_pin_cond irq_pin_cond_chk #(
    .RESTART_CKSTOP (RESTART_CKSTOP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .pending_o  (pending_o),
    .hard_irq_o (hard_irq_o),
    .halt_o     (halt_o),
    .core_rst_o (core_rst_o)
);

// File: tb/irq_pin_cond_tb.sv
module irq_pin_cond_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 8;
    localparam int WATCHDOG   = 100000;
    localparam logic [PIN_W-1:0] IDLE = 8'h04;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PIN_W-1:0] pin_i = IDLE;
    logic [3:0]       ack_i = 4'h0;
    logic [3:0]       pending_o;
    logic             hard_irq_o, halt_o, core_rst_o, tb_run_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_cond #(.PIN_W(PIN_W), .SYNC_STAGES(2), .RESTART_CKSTOP(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ack_i(ack_i),
        .pending_o(pending_o), .hard_irq_o(hard_irq_o), .halt_o(halt_o),
        .core_rst_o(core_rst_o), .tb_run_o(tb_run_o)
    );

    // Behavioural reference: pins seen two edges late, acted on at the third.
    logic [PIN_W-1:0] dly_q[$];
    logic [PIN_W-1:0] m_last;
    logic [3:0]       m_pend;
    logic             m_halt, m_rst, m_tb;

    task automatic model_reset();
        dly_q.delete();
        dly_q.push_back(IDLE);
        dly_q.push_back(IDLE);
        m_last = IDLE; m_pend = 0; m_halt = 0; m_rst = 0; m_tb = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic [PIN_W-1:0] seen;
            seen = dly_q.pop_front();
            dly_q.push_back(pin_i);
            m_rst = 0;
            if (ack_i[2]) m_pend[2] = 0;
            for (int i = 0; i < 7; i++) begin
                if (seen[i] !== m_last[i]) begin
                    case (i)
                        0: m_pend[0] = seen[i];
                        1: m_pend[1] = seen[i];
                        5: m_pend[3] = seen[i];
                        2: if (!seen[i]) m_pend[2] = 1;
                        3: m_halt = seen[i];
                        4: if (seen[i]) m_rst = 1;
                        6: m_tb = seen[i];
                        default: ;
                    endcase
                    m_last[i] = seen[i];
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 model pending", pending_o, m_pend);
            check("R7 model hard_irq", hard_irq_o, |m_pend);
            check("R6 model halt", halt_o, m_halt);
            check("R5 model core_rst", core_rst_o, m_rst);
            check("R8 model tb_run", tb_run_o, m_tb);
        end
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int pulses;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R10 reset state
        check("R10 pending", pending_o, 0);
        check("R10 halt", halt_o, 0);
        check("R10 core_rst", core_rst_o, 0);
        check("R10 tb_run", tb_run_o, 0);
        check("R10 hard_irq", hard_irq_o, 0);
        wait_n(3);
        check("R10 mck idle no latch", pending_o[2], 0);

        // R1 latency and R2 mirroring
        pin_i[0] = 1; wait_n(2);
        check("R1 not yet", pending_o[0], 0);
        wait_n(1);
        check("R1 due", pending_o[0], 1);
        check("R7 raised", hard_irq_o, 1);
        pin_i[1] = 1; wait_n(3);
        check("R2 ext+smi", pending_o, 4'b0011);
        pin_i[0] = 0; wait_n(3);
        check("R2 ext cleared", pending_o, 4'b0010);
        check("R7 still high", hard_irq_o, 1);
        pin_i[1] = 0; wait_n(3);
        check("R2 smi cleared", pending_o, 0);
        check("R7 dropped", hard_irq_o, 0);
        pin_i[5] = 1; wait_n(3);
        check("R2 srst set", pending_o, 4'b1000);

        // R4 ack ignored for mirrored bits
        ack_i = 4'b1011; wait_n(1); ack_i = 0; wait_n(2);
        check("R4 mirrored ack ignored", pending_o, 4'b1000);
        pin_i[5] = 0; wait_n(3);
        check("R2 srst cleared", pending_o, 0);

        // R3 machine check falling edge latch
        pin_i[2] = 0; wait_n(3);
        check("R3 fall latches", pending_o[2], 1);
        pin_i[2] = 1; wait_n(3);
        check("R3 rise keeps", pending_o[2], 1);
        ack_i[2] = 1; wait_n(1); ack_i[2] = 0;
        check("R4 ack clears mck", pending_o[2], 0);
        pin_i[2] = 0; wait_n(3);
        check("R3 second fall", pending_o[2], 1);
        ack_i[2] = 1; wait_n(1); ack_i[2] = 0; wait_n(4);
        check("R3 held low no relatch", pending_o[2], 0);
        pin_i[2] = 1; wait_n(4);
        check("R3 rise no set", pending_o[2], 0);

        // R5 hard reset pulse
        pulses = 0;
        pin_i[4] = 1;
        for (int k = 0; k < 8; k++) begin wait_n(1); pulses += core_rst_o; end
        check("R5 one pulse on rise", pulses, 1);
        pulses = 0;
        pin_i[4] = 0;
        for (int k = 0; k < 8; k++) begin wait_n(1); pulses += core_rst_o; end
        check("R5 no pulse on fall", pulses, 0);

        // R6 checkstop halt
        pin_i[3] = 1; wait_n(2);
        check("R6 halt not yet", halt_o, 0);
        wait_n(1);
        check("R6 halt set", halt_o, 1);
        pin_i[3] = 0; wait_n(3);
        check("R6 halt released", halt_o, 0);

        // R8 time base
        pin_i[6] = 1; wait_n(3);
        check("R8 tb on", tb_run_o, 1);
        pin_i[6] = 0; wait_n(3);
        check("R8 tb off", tb_run_o, 0);

        // R9 spare pin ignored
        pin_i[0] = 1; wait_n(3);
        for (int k = 0; k < 6; k++) begin
            pin_i[7] = ~pin_i[7]; wait_n(2);
            check("R9 spare pending", pending_o, 4'b0001);
            check("R9 spare others", {halt_o, core_rst_o, tb_run_o}, 0);
        end
        pin_i[0] = 0; pin_i[7] = 0; wait_n(5);
        check("R2 final clear", pending_o, 0);

        finish_run();
    end

endmodule